// File: doc/BRIEF.md
# Bridge discard timer controller

This block keeps the discard-timer controls of a PCI-to-PCI bridge's bridge control register, together with one discard timer for each side of the bridge. When a delayed completion is queued for a side, the bridge pulses that side's start input and the timer begins to count down. When the requesting master retries and takes the data, a claim pulse stops the timer and nothing else happens. If the timer runs out first, the block raises a one-cycle discard pulse so the queue can drop the completion. It also sets a sticky status flag and, when reporting is enabled, sends a one-cycle system-error request toward the primary side.

Software reaches the controls through a 16-bit register at byte offset 0x3E. Bit 8 picks the primary-side timeout and bit 9 picks the secondary-side timeout. Bit 10 is the status flag, which hardware sets and software clears by writing 1. Bit 11 enables system-error reporting. A side that runs in PCI-X mode has no discard timing at all.

Top module: `discard_timer_ctl`

## Requirements
- R1: After reset the register at offset 0x3E reads 0x0000, and the discard and system-error outputs are low.
- R2: Register bits 15:12 and 7:0 always read 0, and writes to them have no effect. A read at any offset other than 0x3E returns 0, and a write to any other offset changes nothing.
- R3: Register bits 8, 9 and 11 are plain read/write bits.
- R4: A side's timeout select bit is sampled when its start pulse is sampled. A value of 0 gives 2^LONG_LOG2 clocks (default 2^15) and a value of 1 gives 2^SHORT_LOG2 clocks (default 2^10). Bit 8 selects for the primary side and bit 9 for the secondary side. If no claim arrives, that side's discard output is high for exactly one cycle, the given number of clocks after the clock edge that sampled the start.
- R5: A claim sampled at any edge up to and including the expiry edge stops the timer. No discard follows, and the status flag does not change.
- R6: A start sampled while the timer is already running reloads it, so the full timeout counts again from that start.
- R7: Status bit 10 is set on the same edge as any discard pulse. Writing 1 to bit 10 clears it. Writing 0 to bit 10 leaves it unchanged, and a write can never set it.
- R8: If a write that clears bit 10 and an expiry land on the same edge, bit 10 ends up set.
- R9: When bit 11 is 1, every discard pulse comes with a one-cycle serr_req pulse in the same cycle. When bit 11 is 0, serr_req stays low.
- R10: If both timers expire on the same edge, both discard outputs pulse together, status bit 10 is set, and serr_req gives only one single-cycle pulse.
- R11: While a side's pcix input is high, its start pulses are ignored and a running timer is cancelled. That side then produces no discard, no status change and no serr_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pri_start | input | 1 | Primary-side completion queued; starts the timer |
| pri_claim | input | 1 | Primary-side completion taken; stops the timer |
| pri_pcix | input | 1 | Primary side runs in PCI-X mode |
| sec_start | input | 1 | Secondary-side completion queued; starts the timer |
| sec_claim | input | 1 | Secondary-side completion taken; stops the timer |
| sec_pcix | input | 1 | Secondary side runs in PCI-X mode |
| pri_discard | output | 1 | One-cycle pulse: primary-side completion discarded |
| sec_discard | output | 1 | One-cycle pulse: secondary-side completion discarded |
| serr_req | output | 1 | One-cycle system-error request toward the primary side |

## Verification
The cases that are hardest to reach from the ports all depend on two events landing on one exact edge. These are a claim on the expiry edge itself, a status-clearing write on the edge where a timer runs out, and both sides expiring together. The bench uses short timeout parameters and counts falling edges from the sampled start pulse. This lets it place the claim, the write or the second start on the computed edge. It then checks the outputs and the read-back register in the cycle after that edge.

// File: rtl/discard_timer_ctl.sv
module discard_timer_ctl #(
  parameter int          LONG_LOG2  = 15,
  parameter int          SHORT_LOG2 = 10,
  parameter logic [7:0]  REG_OFFSET = 8'h3E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        pri_start,
  input  logic        pri_claim,
  input  logic        pri_pcix,
  input  logic        sec_start,
  input  logic        sec_claim,
  input  logic        sec_pcix,
  output logic        pri_discard,
  output logic        sec_discard,
  output logic        serr_req
);
  localparam int CW = LONG_LOG2;
  localparam logic [CW-1:0] LONG_LAST  = CW'((64'd1 << LONG_LOG2) - 64'd1);
  localparam logic [CW-1:0] SHORT_LAST = CW'((64'd1 << SHORT_LOG2) - 64'd1);

  logic pri_sel_q, sec_sel_q, serr_en_q, status_q, serr_q;
  logic [1:0] disc_q, expire;

  wire       addr_hit = (reg_addr == REG_OFFSET);
  wire       wr_hit   = reg_wr && addr_hit;
  wire [1:0] start_v  = {sec_start, pri_start};
  wire [1:0] claim_v  = {sec_claim, pri_claim};
  wire [1:0] pcix_v   = {sec_pcix, pri_pcix};
  wire [1:0] sel_v    = {sec_sel_q, pri_sel_q};

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic          run_q;
    logic [CW-1:0] cnt_q;

    assign expire[s] = run_q && !pcix_v[s] && !start_v[s] && !claim_v[s] && (cnt_q == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (pcix_v[s]) begin
        run_q <= 1'b0;
      end else if (start_v[s]) begin
        run_q <= 1'b1;
        cnt_q <= sel_v[s] ? SHORT_LAST : LONG_LAST;
      end else if (claim_v[s]) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        if (cnt_q == '0) run_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_sel_q <= 1'b0;
      sec_sel_q <= 1'b0;
      serr_en_q <= 1'b0;
      status_q  <= 1'b0;
      serr_q    <= 1'b0;
      disc_q    <= '0;
    end else begin
      if (wr_hit) begin
        pri_sel_q <= reg_wdata[8];
        sec_sel_q <= reg_wdata[9];
        serr_en_q <= reg_wdata[11];
      end
      status_q <= (|expire) || (status_q && !(wr_hit && reg_wdata[10]));
      serr_q   <= (|expire) && serr_en_q;
      disc_q   <= expire;
    end
  end

  assign reg_rdata   = addr_hit ? {4'b0, serr_en_q, status_q, sec_sel_q, pri_sel_q, 8'b0} : 16'h0000;
  assign pri_discard = disc_q[0];
  assign sec_discard = disc_q[1];
  assign serr_req    = serr_q;
endmodule

// File: rtl/discard_timer_ctl_chk.sv
module discard_timer_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] reg_rdata,
  input logic        pri_pcix,
  input logic        sec_pcix,
  input logic        pri_discard,
  input logic        sec_discard,
  input logic        serr_req,
  input logic        status
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:12] == 4'h0) && (reg_rdata[7:0] == 8'h00));

  assert_pri_disc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pri_discard |=> !pri_discard);

  assert_sec_disc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_discard |=> !sec_discard);

  assert_status_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> (pri_discard || sec_discard));

  assert_discard_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_discard || sec_discard) |-> status);

  assert_serr_with_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> (pri_discard || sec_discard));

  assert_serr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |=> !serr_req);

  assert_pri_pcix_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pri_pcix) |-> !pri_discard);

  assert_sec_pcix_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_pcix) |-> !sec_discard);
endmodule

bind discard_timer_ctl discard_timer_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
  .pri_pcix(pri_pcix), .sec_pcix(sec_pcix),
  .pri_discard(pri_discard), .sec_discard(sec_discard),
  .serr_req(serr_req), .status(status_q)
);

// File: tb/tb_discard_timer_ctl.sv
module tb_discard_timer_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_LOG2  = 7;
  localparam int SHORT_LOG2 = 4;
  localparam int LONG_N     = 1 << LONG_LOG2;
  localparam int SHORT_N    = 1 << SHORT_LOG2;
  localparam logic [7:0] OFS = 8'h3E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = OFS;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pri_start = 0, pri_claim = 0, pri_pcix = 0;
  logic        sec_start = 0, sec_claim = 0, sec_pcix = 0;
  logic        pri_discard, sec_discard, serr_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  discard_timer_ctl #(.LONG_LOG2(LONG_LOG2), .SHORT_LOG2(SHORT_LOG2), .REG_OFFSET(OFS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pri_start(pri_start), .pri_claim(pri_claim), .pri_pcix(pri_pcix),
    .sec_start(sec_start), .sec_claim(sec_claim), .sec_pcix(sec_pcix),
    .pri_discard(pri_discard), .sec_discard(sec_discard), .serr_req(serr_req)
  );

  // write data, expected read-back at 0x3E
  localparam logic [31:0] VEC [8] = '{
    {16'hFFFF, 16'h0B00},
    {16'h0000, 16'h0000},
    {16'h0100, 16'h0100},
    {16'h0200, 16'h0200},
    {16'h0800, 16'h0800},
    {16'hF4FF, 16'h0000},
    {16'h0400, 16'h0000},
    {16'h0A00, 16'h0A00}
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = OFS;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = OFS;
  endtask

  task automatic pstart(input bit pri, input bit sec);
    pri_start = pri; sec_start = sec;
    @(negedge clk);
    pri_start = 0; sec_start = 0;
  endtask

  // counts negedges after start until discard on selected side (0 if none within lim)
  task automatic wait_disc(input bit sec, input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if ((sec ? sec_discard : pri_discard) === 1'b1) begin n = i; break; end
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] d;
    int n, serr_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(OFS, d); check("R1", "reset read", d, 16'h0000);
    check("R1", "reset outputs", {13'b0, pri_discard, sec_discard, serr_req}, 16'h0000);

    // R2 R3 R7: vector walk of write / read-back
    for (int i = 0; i < 8; i++) begin
      wr(OFS, VEC[i][31:16]);
      rd(OFS, d);
      check("R3", $sformatf("vector %0d (R2/R7 no set)", i), d, VEC[i][15:0]);
    end

    // R2 other offsets
    rd(8'h3C, d); check("R2", "read other offset", d, 16'h0000);
    wr(8'h3C, 16'h0000);
    rd(OFS, d); check("R2", "write other offset ignored", d, 16'h0A00);

    // R4 primary long
    wr(OFS, 16'h0000);
    pstart(1, 0); wait_disc(0, LONG_N + 4, n);
    check("R4", "pri long latency", n[15:0], LONG_N[15:0]);
    @(negedge clk); check("R4", "pri discard single", {15'b0, pri_discard}, 16'h0);
    check("R9", "serr off", {15'b0, serr_req}, 16'h0);
    rd(OFS, d); check("R7", "status set by expiry", d, 16'h0400);
    wr(OFS, 16'h0000);
    rd(OFS, d); check("R7", "write 0 keeps status", d, 16'h0400);
    wr(OFS, 16'h0400);
    rd(OFS, d); check("R7", "write 1 clears status", d, 16'h0000);

    // R4 primary short, R9 serr on
    wr(OFS, 16'h0900);
    pri_start = 1; @(negedge clk); pri_start = 0;
    serr_cnt = 0;
    for (int i = 1; i <= SHORT_N; i++) begin
      @(negedge clk);
      if (i == SHORT_N) begin
        check("R4", "pri short discard", {15'b0, pri_discard}, 16'h1);
        check("R9", "serr with discard", {15'b0, serr_req}, 16'h1);
      end else if (pri_discard) begin
        check("R4", "pri short early discard", 16'h1, 16'h0);
      end
    end
    @(negedge clk); check("R9", "serr single", {15'b0, serr_req}, 16'h0);

    // R4 secondary short via bit 9, primary short setting not used
    wr(OFS, 16'h0200);
    pstart(0, 1); wait_disc(1, LONG_N + 4, n);
    check("R4", "sec short latency", n[15:0], SHORT_N[15:0]);
    wr(OFS, 16'h0000);
    pstart(0, 1); wait_disc(1, LONG_N + 4, n);
    check("R4", "sec long latency", n[15:0], LONG_N[15:0]);
    wr(OFS, 16'h0400);

    // R5 claim on the expiry edge
    wr(OFS, 16'h0100);
    pstart(1, 0);
    repeat (SHORT_N - 1) @(negedge clk);
    pri_claim = 1; @(negedge clk); pri_claim = 0;
    check("R5", "claim at expiry edge", {15'b0, pri_discard}, 16'h0);
    wait_disc(0, 2 * SHORT_N, n);
    check("R5", "no later discard", n[15:0], 16'h0);
    rd(OFS, d); check("R5", "status untouched", d, 16'h0100);

    // R6 restart reloads
    pstart(1, 0);
    repeat (5) @(negedge clk);
    pstart(1, 0); wait_disc(0, LONG_N, n);
    check("R6", "restart latency", n[15:0], SHORT_N[15:0]);

    // R8 clear write on expiry edge (status already 1)
    rd(OFS, d); check("R8", "status preset", d, 16'h0500);
    pstart(1, 0);
    repeat (SHORT_N - 1) @(negedge clk);
    wr(OFS, 16'h0500);
    check("R8", "discard on clear edge", {15'b0, pri_discard}, 16'h1);
    rd(OFS, d); check("R8", "status stays set", d, 16'h0500);

    // R10 both sides expire together
    wr(OFS, 16'h0F00);
    pstart(1, 1);
    serr_cnt = 0;
    for (int i = 1; i <= SHORT_N + 3; i++) begin
      @(negedge clk);
      if (serr_req) serr_cnt++;
      if (i == SHORT_N)
        check("R10", "both discards", {14'b0, pri_discard, sec_discard}, 16'h3);
    end
    check("R10", "single serr pulse", serr_cnt[15:0], 16'h1);
    rd(OFS, d); check("R10", "status set", d, 16'h0F00);
    wr(OFS, 16'h0F00);

    // R11 pcix: start ignored, running timer cancelled
    pri_pcix = 1;
    pstart(1, 0); wait_disc(0, 2 * SHORT_N, n);
    check("R11", "pcix start ignored", n[15:0], 16'h0);
    pri_pcix = 0;
    pstart(1, 0);
    repeat (3) @(negedge clk);
    pri_pcix = 1; @(negedge clk); pri_pcix = 0;
    serr_cnt = 0;
    for (int i = 0; i < 2 * SHORT_N; i++) begin
      @(negedge clk);
      if (pri_discard || serr_req) serr_cnt++;
    end
    check("R11", "pcix cancels timer", serr_cnt[15:0], 16'h0);
    rd(OFS, d); check("R11", "no status from pcix side", d, 16'h0B00);

    done = 1;
    report();
  end
endmodule